// File: doc/BRIEF.md
# Status Byte and Service Request Aggregator

This block builds the 8-bit summary status byte of an instrument's status system and derives from it a request-service bit. Two bits of the byte follow live levels: the error queue is not empty, and an output message is waiting. Two more are summary bits handed up by the operation and questionable status groups. One bit summarises a standard event register that the block holds itself.

The standard event register captures one-cycle pulses for these events: operation complete, query error, device-dependent error, execution error and command error. It also sets a power-on flag once after reset. A captured bit stays set until software reads the register or issues a clear-status command. The register is ANDed with an enable mask, and the OR of the result feeds the status byte.

A small register bus carries one access per cycle. The access is `bus_valid`, with `bus_write` giving the direction and a 2-bit address. Through it, software reads the status byte, reads and writes the two enable masks, reads the event register, and issues clear-status by writing to the status byte address. Reads are combinational, so data is valid in the cycle of the access. Any side effect of an access takes place at the following clock edge.

Top module: `status_byte_agg`

## Requirements
- R1: Status byte bits 1 and 0 are always 0.
- R2: Status byte bit 2 equals `errq_nonempty` and bit 4 equals `msg_avail`, in the same cycle.
- R3: Status byte bit 3 equals `quest_sum` and bit 7 equals `oper_sum`, in the same cycle.
- R4: Status byte bit 5 is the OR over the event register ANDed with the event enable register (address 3).
- R5: Status byte bit 6 and the `srq` output are both the OR of status byte bits 0-5 and 7, each ANDed with the matching bit of the service enable register (address 1). Bit 6 of that register has no effect.
- R6: Each event pulse sets one bit of the event register (address 2): `evt_opc` sets bit 0, `evt_qry_err` sets bit 2, `evt_dev_err` sets bit 3, `evt_exe_err` sets bit 4 and `evt_cmd_err` sets bit 5. Bits 1 and 6 always read 0.
- R7: Event bits stay set until one of two things happens. A read of address 2 returns the current value and clears the register at the following edge. A write to address 0 (clear-status) also clears it.
- R8: A pulse that arrives in the same cycle as a clear leaves its event bit set after that edge.
- R9: Synchronous reset clears every register and both enable registers. Event bit 7 (power on) is set at the first clock edge after reset is released.
- R10: The service enable register (address 1) and the event enable register (address 3) are written and read back in full. Reading them changes nothing. Writes to address 2 are ignored, and clear-status leaves both enable registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_opc | input | 1 | Operation-complete pulse |
| evt_qry_err | input | 1 | Query error pulse |
| evt_dev_err | input | 1 | Device-dependent error pulse |
| evt_exe_err | input | 1 | Execution error pulse |
| evt_cmd_err | input | 1 | Command error pulse |
| errq_nonempty | input | 1 | Error queue holds an entry |
| msg_avail | input | 1 | Output data waiting |
| quest_sum | input | 1 | Questionable group summary |
| oper_sum | input | 1 | Operation group summary |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 status/clear, 1 service enable, 2 events, 3 event enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| status_byte | output | 8 | Live summary status byte |
| srq | output | 1 | Request-service (master summary) bit |

## Verification
The assertions take three things for granted. Every event input is a clean one-cycle pulse or a held level, known on every sampled edge. Only one bus access is made per cycle. No input carries X after reset. The bench meets these conditions by driving all inputs only on falling edges, to fixed 0/1 values. It holds bus controls for exactly one cycle per access and never overlaps two accesses. The sweeps are exhaustive over the four level inputs, every service enable value, every event enable value, and every combination of the five error and completion pulses.

// File: rtl/sbagg_pkg.sv
package sbagg_pkg;

    localparam int SB_W   = 8;
    localparam int ADDR_W = 2;

    // Status byte positions
    localparam int SB_ERRQ  = 2;
    localparam int SB_QUEST = 3;
    localparam int SB_MAV   = 4;
    localparam int SB_STD   = 5;
    localparam int SB_MSS   = 6;
    localparam int SB_OPER  = 7;

    // Event register positions
    localparam int EV_OPC = 0;
    localparam int EV_QRY = 2;
    localparam int EV_DEV = 3;
    localparam int EV_EXE = 4;
    localparam int EV_CMD = 5;
    localparam int EV_PON = 7;

    localparam logic [SB_W-1:0] EV_LIVE_MASK = 8'b1011_1101;
    localparam logic [SB_W-1:0] MSS_EXCLUDE  = 8'b1011_1111;

    typedef enum logic [ADDR_W-1:0] {
        A_STB = 2'd0,
        A_SRE = 2'd1,
        A_EVT = 2'd2,
        A_EEN = 2'd3
    } bus_addr_e;

    typedef struct packed {
        logic pon;
        logic cmd;
        logic exe;
        logic dev;
        logic qry;
        logic opc;
    } evt_pulse_t;

    typedef struct packed {
        logic oper;
        logic std_sum;
        logic mav;
        logic quest;
        logic errq;
    } sb_src_t;

    function automatic logic [SB_W-1:0] pulses_to_bits(input evt_pulse_t p);
        logic [SB_W-1:0] v;
        v = '0;
        v[EV_OPC] = p.opc;
        v[EV_QRY] = p.qry;
        v[EV_DEV] = p.dev;
        v[EV_EXE] = p.exe;
        v[EV_CMD] = p.cmd;
        v[EV_PON] = p.pon;
        return v;
    endfunction

endpackage

// File: rtl/sbagg_enables.sv
module sbagg_enables
    import sbagg_pkg::*;
#(
    parameter int W = SB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_sre,
    input  logic         wr_een,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] sre_q,
    output logic [W-1:0] een_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sre_q <= '0;
            een_q <= '0;
        end else begin
            if (wr_sre) sre_q <= wdata;
            if (wr_een) een_q <= wdata;
        end
    end
endmodule

// File: rtl/sbagg_event_reg.sv
module sbagg_event_reg
    import sbagg_pkg::*;
#(
    parameter int W = SB_W
) (
    input  logic       clk,
    input  logic       rst,
    input  evt_pulse_t pulses,
    input  logic       clr,
    output logic [W-1:0] evt_q
);
    logic            pon_pend;
    evt_pulse_t      p_all;
    logic [W-1:0]    set_bits;
    logic [W-1:0]    kept;

    always_comb begin
        p_all     = pulses;
        p_all.pon = pulses.pon | pon_pend;
        set_bits  = pulses_to_bits(p_all);
        kept      = clr ? '0 : evt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q    <= '0;
            pon_pend <= 1'b1;
        end else begin
            pon_pend <= 1'b0;
            evt_q    <= (kept | set_bits) & EV_LIVE_MASK;
        end
    end
endmodule

// File: rtl/sbagg_summary.sv
module sbagg_summary
    import sbagg_pkg::*;
#(
    parameter int W = SB_W
) (
    input  sb_src_t      src,
    input  logic [W-1:0] sre,
    output logic [W-1:0] status_byte,
    output logic         mss
);
    logic [W-1:0] base;
    logic [W-1:0] masked;

    always_comb begin
        base           = '0;
        base[SB_ERRQ]  = src.errq;
        base[SB_QUEST] = src.quest;
        base[SB_MAV]   = src.mav;
        base[SB_STD]   = src.std_sum;
        base[SB_OPER]  = src.oper;
    end

    for (genvar i = 0; i < W; i++) begin : g_mask
        if (i == SB_MSS) begin : g_self
            assign masked[i] = 1'b0;
        end else begin : g_bit
            assign masked[i] = base[i] & sre[i] & MSS_EXCLUDE[i];
        end
    end

    assign mss = |masked;

    always_comb begin
        status_byte         = base;
        status_byte[SB_MSS] = mss;
    end
endmodule

// File: rtl/status_byte_agg.sv
module status_byte_agg
    import sbagg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt_opc,
    input  logic       evt_qry_err,
    input  logic       evt_dev_err,
    input  logic       evt_exe_err,
    input  logic       evt_cmd_err,
    input  logic       errq_nonempty,
    input  logic       msg_avail,
    input  logic       quest_sum,
    input  logic       oper_sum,
    input  logic       bus_valid,
    input  logic       bus_write,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic [7:0] status_byte,
    output logic       srq
);
    bus_addr_e   addr;
    logic        wr_sre, wr_een, evt_clr;
    logic [7:0]  sre_q, een_q, evt_q;
    evt_pulse_t  pulses;
    sb_src_t     src;

    assign addr    = bus_addr_e'(bus_addr);
    assign wr_sre  = bus_valid &  bus_write & (addr == A_SRE);
    assign wr_een  = bus_valid &  bus_write & (addr == A_EEN);
    assign evt_clr = bus_valid & ((bus_write & (addr == A_STB)) |
                                  (!bus_write & (addr == A_EVT)));

    always_comb begin
        pulses     = '0;
        pulses.opc = evt_opc;
        pulses.qry = evt_qry_err;
        pulses.dev = evt_dev_err;
        pulses.exe = evt_exe_err;
        pulses.cmd = evt_cmd_err;
    end

    sbagg_enables #(.W(SB_W)) u_en (
        .clk(clk), .rst(rst), .wr_sre(wr_sre), .wr_een(wr_een),
        .wdata(bus_wdata), .sre_q(sre_q), .een_q(een_q)
    );

    sbagg_event_reg #(.W(SB_W)) u_evt (
        .clk(clk), .rst(rst), .pulses(pulses), .clr(evt_clr), .evt_q(evt_q)
    );

    always_comb begin
        src.errq    = errq_nonempty;
        src.quest   = quest_sum;
        src.mav     = msg_avail;
        src.std_sum = |(evt_q & een_q);
        src.oper    = oper_sum;
    end

    sbagg_summary #(.W(SB_W)) u_sum (
        .src(src), .sre(sre_q), .status_byte(status_byte), .mss(srq)
    );

    always_comb begin
        unique case (addr)
            A_STB:   bus_rdata = status_byte;
            A_SRE:   bus_rdata = sre_q;
            A_EVT:   bus_rdata = evt_q;
            default: bus_rdata = een_q;
        endcase
    end
endmodule

// File: rtl/sbagg_checker.sv
module sbagg_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] status_byte,
    input logic       srq,
    input logic       errq_nonempty,
    input logic       msg_avail,
    input logic       quest_sum,
    input logic       oper_sum,
    input logic       evt_cmd_err,
    input logic       evt_clr,
    input logic [7:0] evt_q,
    input logic [7:0] een_q,
    input logic [7:0] sre_q
);
    p_low_zero_r1: assert property (@(posedge clk) disable iff (rst)
        status_byte[1:0] == 2'b00);

    p_levels_r2: assert property (@(posedge clk) disable iff (rst)
        status_byte[2] == errq_nonempty && status_byte[4] == msg_avail);

    p_groups_r3: assert property (@(posedge clk) disable iff (rst)
        status_byte[3] == quest_sum && status_byte[7] == oper_sum);

    p_std_sum_r4: assert property (@(posedge clk) disable iff (rst)
        status_byte[5] == |(evt_q & een_q));

    p_srq_r5: assert property (@(posedge clk) disable iff (rst)
        srq == status_byte[6] && srq == |(status_byte & sre_q & 8'hBF));

    p_reserved_r6: assert property (@(posedge clk) disable iff (rst)
        evt_q[1] == 1'b0 && evt_q[6] == 1'b0);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !evt_clr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

    p_pulse_wins_r8: assert property (@(posedge clk) disable iff (rst)
        evt_cmd_err |=> evt_q[5]);
endmodule

bind status_byte_agg sbagg_checker u_chk (
    .clk(clk), .rst(rst), .status_byte(status_byte), .srq(srq),
    .errq_nonempty(errq_nonempty), .msg_avail(msg_avail),
    .quest_sum(quest_sum), .oper_sum(oper_sum), .evt_cmd_err(evt_cmd_err),
    .evt_clr(evt_clr), .evt_q(evt_q), .een_q(een_q), .sre_q(sre_q)
);

// File: tb/sim_status_byte_agg.sv
`timescale 1ns/1ps
module sim_status_byte_agg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_opc = 0, evt_qry_err = 0, evt_dev_err = 0, evt_exe_err = 0, evt_cmd_err = 0;
    logic       errq_nonempty = 0, msg_avail = 0, quest_sum = 0, oper_sum = 0;
    logic       bus_valid = 0, bus_write = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata, status_byte;
    logic       srq;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    status_byte_agg u0 (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic pulse(input logic [4:0] p);
        @(negedge clk);
        {evt_cmd_err, evt_exe_err, evt_dev_err, evt_qry_err, evt_opc} = p;
        @(negedge clk);
        {evt_cmd_err, evt_exe_err, evt_dev_err, evt_qry_err, evt_opc} = '0;
    endtask

    function automatic logic [7:0] ev_bits(input logic [4:0] p);
        return {2'b00, p[4], p[3], p[2], p[1], 1'b0, p[0]};
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset status byte", status_byte, 8'h00);
        bus_addr = 2'd1; #1 check("R9 reset sre", bus_rdata, 8'h00);
        bus_addr = 2'd3; #1 check("R9 reset een", bus_rdata, 8'h00);
        bus_addr = 2'd2; #1 check("R9 reset events", bus_rdata, 8'h00);
        @(negedge clk); rst = 0;
        @(negedge clk);
        // R9: power-on bit after first edge out of reset
        bus_rd(2'd2, rd); check("R9 power-on", rd, 8'h80);
        bus_rd(2'd2, rd); check("R7 read clears", rd, 8'h00);

        // R1, R2, R3, R5: all service enables by all level patterns
        for (int s = 0; s < 256; s++) begin
            bus_wr(2'd1, s[7:0]);
            for (int lv = 0; lv < 16; lv++) begin
                logic [7:0] e;
                logic m;
                @(negedge clk);
                {oper_sum, msg_avail, quest_sum, errq_nonempty} = lv[3:0];
                #1;
                e = {lv[3], 1'b0, 1'b0, lv[2], lv[1], lv[0], 2'b00};
                m = |(e & s[7:0] & 8'hBF);
                e[6] = m;
                check("R1 R2 R3 R5 status byte", status_byte, e);
                check("R5 srq", {7'd0, srq}, {7'd0, m});
            end
        end
        @(negedge clk);
        {oper_sum, msg_avail, quest_sum, errq_nonempty} = '0;

        // R10: enable access, reads do not change
        bus_wr(2'd1, 8'hA5);
        bus_rd(2'd1, rd); check("R10 sre read", rd, 8'hA5);
        bus_rd(2'd1, rd); check("R10 sre reread", rd, 8'hA5);
        bus_wr(2'd3, 8'h3C);
        bus_rd(2'd3, rd); check("R10 een read", rd, 8'h3C);
        bus_wr(2'd0, 8'h00);
        bus_rd(2'd1, rd); check("R10 sre after clear", rd, 8'hA5);
        bus_rd(2'd3, rd); check("R10 een after clear", rd, 8'h3C);
        bus_wr(2'd2, 8'hFF);
        bus_rd(2'd2, rd); check("R10 event write ignored", rd, 8'h00);

        // R4, R6, R7: all event enables by all pulse patterns
        bus_wr(2'd1, 8'h20);
        for (int en = 0; en < 256; en++) begin
            bus_wr(2'd3, en[7:0]);
            for (int p = 0; p < 32; p++) begin
                logic [7:0] eb;
                logic sm;
                bus_wr(2'd0, 8'h00);
                pulse(p[4:0]);
                eb = ev_bits(p[4:0]);
                sm = |(eb & en[7:0]);
                check("R4 std summary", {7'd0, status_byte[5]}, {7'd0, sm});
                check("R5 srq via std", {7'd0, srq}, {7'd0, sm});
                bus_rd(2'd2, rd); check("R6 event layout", rd, eb);
                bus_rd(2'd2, rd); check("R7 cleared by read", rd, 8'h00);
            end
        end

        // R7: held until clear-status
        pulse(5'b00100);
        repeat (5) @(negedge clk);
        bus_rd(2'd0, rd);
        bus_rd(2'd2, rd); check("R7 held", rd, 8'h08);
        pulse(5'b00010);
        bus_wr(2'd0, 8'h00);
        bus_rd(2'd2, rd); check("R7 clear-status", rd, 8'h00);

        // R8: pulse coincident with clear-status
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 2'd0; evt_cmd_err = 1;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; evt_cmd_err = 0;
        bus_rd(2'd2, rd); check("R8 pulse with clear-status", rd, 8'h20);
        // R8: pulse coincident with clearing read
        pulse(5'b00001);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = 2'd2; evt_exe_err = 1;
        #1 check("R8 read returns old", bus_rdata, 8'h01);
        @(negedge clk);
        bus_valid = 0; evt_exe_err = 0;
        bus_rd(2'd2, rd); check("R8 pulse with read", rd, 8'h10);

        // R9: reset clears enables and events, power-on returns
        bus_wr(2'd3, 8'hFF);
        pulse(5'b11111);
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk);
        bus_addr = 2'd3; #1 check("R9 re-reset een", bus_rdata, 8'h00);
        bus_addr = 2'd2; #1 check("R9 re-reset events", bus_rdata, 8'h00);
        rst = 0;
        @(negedge clk);
        bus_rd(2'd2, rd); check("R9 power-on again", rd, 8'h80);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule